// File: doc/BRIEF.md
# Prescaled Match Counter Timer

This block is a general purpose timer with four compare channels. A programmable prescaler divides the peripheral clock so that a 32-bit counter moves forward once every (divisor + 1) clocks. Each channel holds a 32-bit compare value. When the counter arrives at that value and the channel's interrupt enable is set, the channel raises a sticky pending flag. Software clears the flag by writing a one to it.

Software controls the block through a simple synchronous word port. A write takes effect on the clock edge where `reg_we` is high. Read data is combinational from `reg_addr`. A single interrupt line is high while any enabled channel has a pending flag.

The word map is as follows. Address 0 is control: bit 0 is run, bits 5:4 are the count mode. Address 1 is the prescale divisor. Address 2 is the counter, which can be read and also loaded. Address 3 is match control. Address 4 holds the pending flags. Addresses 8 to 11 are the compare values of channels 0 to 3. Unmapped addresses read as zero.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: With a prescale divisor of P, the counter rises by one every P+1 clocks while it runs. P=0 means it rises on every clock. The prescale phase starts at zero after a counter load.
- R3: Control bit 0 starts the counter when set. When it is clear, the counter value holds.
- R4: The mode field in control bits 5:4 selects counting only at value 0. Any other value holds the counter even when bit 0 is set.
- R5: The counter reads back at address 2 at any time. A write to address 2 loads it. It wraps from 0xFFFFFFFF to 0 and keeps counting.
- R6: Match control has one enable per channel, at bit 3×n (bits 0, 3, 6 and 9). Only these bits are stored. All other bits read as zero.
- R7: Flag n (bit n of address 4) is set on the prescaler tick where the counter becomes equal to compare value n, and only if enable n is set. It is set once per such event, not again while the counter stays equal.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R9: `irq` is the OR over channels of flag AND enable. Clearing an enable masks its flag without clearing it.
- R10: A write to the prescale divisor restarts the prescale phase from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the only way to change the counter other than by counting is a software write to address 2, and that flags drop only through a write-one clear. Every check on counter hold and single steps is therefore disabled in cycles that load the counter. The stimulus drives the port only on falling edges. It loads the counter before each timed scenario and clears stale flags before any new compare test, so every expected count is fixed by the divisor and the number of clock edges.

// File: rtl/match_timer_pkg.sv
// Package: shared register addresses, field positions and mode codes
// for the prescaled match counter timer.
package match_timer_pkg;
    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_PRESCALE = 1;
    localparam int ADDR_COUNT    = 2;
    localparam int ADDR_MCTL     = 3;
    localparam int ADDR_FLAGS    = 4;
    localparam int ADDR_MATCH0   = 8;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_MODE_LSB = 4;
    localparam int MCTL_STRIDE   = 3;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'd0,
        MODE_RSV1  = 2'd1,
        MODE_RSV2  = 2'd2,
        MODE_RSV3  = 2'd3
    } count_mode_e;
endpackage

// File: rtl/mt_prescaler.sv
// Prescaler: counts peripheral clocks while enabled and pulses tick
// once every (limit + 1) clocks. Assumes restart is asserted whenever the
// limit changes, so the phase never sits above the limit.
module mt_prescaler #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [WIDTH-1:0] limit,
    input  logic             restart,
    output logic             tick
);
    logic [WIDTH-1:0] phase_q;

    assign tick = enable && (phase_q == limit);

    // Advance the phase, wrap it on tick, zero it on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (enable) begin
            if (tick) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mt_counter.sv
// Timer counter: loads from software, otherwise steps by one on advance.
// Wraps naturally at its full width. Also provides the value it will hold
// after the next step so the channels can detect the equality event.
module mt_counter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             advance,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] next_count
);
    assign next_count = count + 1'b1;

    // Hold, load or step the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (advance) begin
            count <= next_count;
        end
    end
endmodule

// File: rtl/mt_match_channel.sv
// Match channel: holds one compare value and a sticky pending flag.
// The flag is set on the step where the counter becomes equal to the
// compare value (when enabled) and cleared by a write-one request.
// A set in the same cycle as a clear wins.
module mt_match_channel #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_match,
    input  logic [WIDTH-1:0] wdata,
    input  logic             step,
    input  logic [WIDTH-1:0] next_count,
    input  logic             enable,
    input  logic             clear,
    output logic [WIDTH-1:0] match_val,
    output logic             flag
);
    logic hit;

    assign hit = step && enable && (next_count == match_val);

    // Store the compare value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_val <= '0;
        end else if (wr_match) begin
            match_val <= wdata;
        end
    end

    // Set the flag on a match event, clear it on a write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (clear) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/match_timer.sv
// Top: prescaled match counter timer with a synchronous register port.
// Decodes writes, holds control/prescale/enable registers, builds the
// read mux and the combined interrupt. Assumes 3*CHANNELS <= DATA_W and
// that all compare addresses fit in ADDR_W.
module match_timer #(
    parameter int DATA_W   = 32,
    parameter int CHANNELS = 4,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    import match_timer_pkg::*;

    localparam int MATCH_LAST = ADDR_MATCH0 + CHANNELS - 1;

    logic                run_q;
    count_mode_e         mode_q;
    logic [DATA_W-1:0]   prescale_q;
    logic [CHANNELS-1:0] ien_q;
    logic [CHANNELS-1:0] flags_q;
    logic [DATA_W-1:0]   match_q [CHANNELS];
    logic [DATA_W-1:0]   count_q;
    logic [DATA_W-1:0]   next_count;
    logic                tick;
    logic                wr_ctrl, wr_psc, wr_count, wr_mctl, wr_flags;
    logic                count_en;
    logic                step;

    assign wr_ctrl  = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign wr_psc   = reg_we && (reg_addr == ADDR_W'(ADDR_PRESCALE));
    assign wr_count = reg_we && (reg_addr == ADDR_W'(ADDR_COUNT));
    assign wr_mctl  = reg_we && (reg_addr == ADDR_W'(ADDR_MCTL));
    assign wr_flags = reg_we && (reg_addr == ADDR_W'(ADDR_FLAGS));

    assign count_en = run_q && (mode_q == MODE_TIMER);
    assign step     = tick && !wr_count;

    // Control register: run bit and count mode field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            mode_q <= MODE_TIMER;
        end else if (wr_ctrl) begin
            run_q  <= reg_wdata[CTRL_RUN_BIT];
            mode_q <= count_mode_e'(reg_wdata[CTRL_MODE_LSB +: 2]);
        end
    end

    // Prescale divisor register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale_q <= '0;
        end else if (wr_psc) begin
            prescale_q <= reg_wdata;
        end
    end

    // Match control: keep only the per-channel enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (wr_mctl) begin
            for (int n = 0; n < CHANNELS; n++) begin
                ien_q[n] <= reg_wdata[MCTL_STRIDE*n];
            end
        end
    end

    mt_prescaler #(.WIDTH(DATA_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (count_en),
        .limit   (prescale_q),
        .restart (wr_psc || wr_count),
        .tick    (tick)
    );

    mt_counter #(.WIDTH(DATA_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_count),
        .load_val   (reg_wdata),
        .advance    (tick),
        .count      (count_q),
        .next_count (next_count)
    );

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        mt_match_channel #(.WIDTH(DATA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_match   (reg_we && (reg_addr == ADDR_W'(ADDR_MATCH0 + g))),
            .wdata      (reg_wdata),
            .step       (step),
            .next_count (next_count),
            .enable     (ien_q[g]),
            .clear      (wr_flags && reg_wdata[g]),
            .match_val  (match_q[g]),
            .flag       (flags_q[g])
        );
    end

    // Read mux over all mapped registers.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata[CTRL_RUN_BIT]       = run_q;
            reg_rdata[CTRL_MODE_LSB +: 2] = mode_q;
        end else if (reg_addr == ADDR_W'(ADDR_PRESCALE)) begin
            reg_rdata = prescale_q;
        end else if (reg_addr == ADDR_W'(ADDR_COUNT)) begin
            reg_rdata = count_q;
        end else if (reg_addr == ADDR_W'(ADDR_MCTL)) begin
            for (int n = 0; n < CHANNELS; n++) begin
                reg_rdata[MCTL_STRIDE*n] = ien_q[n];
            end
        end else if (reg_addr == ADDR_W'(ADDR_FLAGS)) begin
            reg_rdata[CHANNELS-1:0] = flags_q;
        end else begin
            for (int n = 0; n < CHANNELS; n++) begin
                if (reg_addr == ADDR_W'(ADDR_MATCH0 + n)) begin
                    reg_rdata = match_q[n];
                end
            end
        end
    end

    // Combined interrupt from enabled pending flags.
    assign irq = |(flags_q & ien_q);

    logic unused_ok;
    assign unused_ok = (MATCH_LAST > 0);
endmodule

// File: rtl/match_timer_chk.sv
// Checker: temporal properties of the timer, attached to the top by bind.
// Assumes the counter changes only by counting or by a software load.
module match_timer_chk #(
    parameter int DATA_W   = 32,
    parameter int CHANNELS = 4,
    parameter int ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic                run_q,
    input logic [1:0]          mode_q,
    input logic                tick,
    input logic [DATA_W-1:0]   count_q,
    input logic [CHANNELS-1:0] flags_q,
    input logic [CHANNELS-1:0] ien_q,
    input logic                irq
);
    import match_timer_pkg::*;

    logic ld;
    logic clr_wr;
    assign ld     = reg_we && (reg_addr == ADDR_W'(ADDR_COUNT));
    assign clr_wr = reg_we && (reg_addr == ADDR_W'(ADDR_FLAGS));

    AST_TICK_ONLY_WHEN_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (run_q && mode_q == 2'd0)); // R2

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !ld) |=> $stable(count_q)); // R3

    AST_HOLD_IN_OTHER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 2'd0 && !ld) |=> $stable(count_q)); // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1)); // R5

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags_q != '0)); // R9

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chk
        AST_FLAG_SET_ON_ENABLED_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_q[g]) |-> ($past(ien_q[g]) && $past(tick))); // R7

        AST_FLAG_DROP_BY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags_q[g]) |-> $past(clr_wr && reg_wdata[g])); // R8
    end
endmodule

bind match_timer match_timer_chk #(
    .DATA_W   (DATA_W),
    .CHANNELS (CHANNELS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .run_q     (run_q),
    .mode_q    (mode_q),
    .tick      (tick),
    .count_q   (count_q),
    .flags_q   (flags_q),
    .ien_q     (ien_q),
    .irq       (irq)
);

// File: tb/match_timer_test.sv
`timescale 1ns/1ps
module match_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [3:0] A_CTRL = 4'd0, A_PSC = 4'd1, A_CNT = 4'd2,
                           A_MCTL = 4'd3, A_FLG = 4'd4, A_M0 = 4'd8;

    // {prescale, edges after start, expected count}
    localparam logic [31:0] VEC [0:5][0:2] = '{
        '{32'd0, 32'd5,  32'd5},
        '{32'd1, 32'd6,  32'd3},
        '{32'd2, 32'd7,  32'd2},
        '{32'd3, 32'd3,  32'd0},
        '{32'd3, 32'd4,  32'd1},
        '{32'd9, 32'd25, 32'd2}
    };

    always #4 clk = ~clk;

    match_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got %h expected %h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c1;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            chk("R1 register zero", v, 32'd0);
        end
        chk("R1 irq low", {31'd0, irq}, 32'd0);

        // R2: vector table of prescale divisors
        for (int i = 0; i < 6; i++) begin
            wr(A_CTRL, 32'd0);
            wr(A_CNT, 32'd0);
            wr(A_PSC, VEC[i][0]);
            wr(A_CTRL, 32'd1);
            idle(int'(VEC[i][1]));
            rd(A_CNT, v);
            chk("R2 prescaled count", v, VEC[i][2]);
        end

        // R3: stop holds the counter
        wr(A_CTRL, 32'd0);
        rd(A_CNT, c1);
        idle(5);
        rd(A_CNT, v);
        chk("R3 hold when stopped", v, c1);

        // R4: nonzero mode holds, mode 0 counts
        wr(A_CNT, 32'd7);
        wr(A_PSC, 32'd0);
        wr(A_CTRL, 32'h11);
        idle(5);
        rd(A_CNT, v);
        chk("R4 hold in mode 1", v, 32'd7);
        wr(A_CTRL, 32'h01);
        idle(2);
        rd(A_CNT, v);
        chk("R4 counting in mode 0", v, 32'd9);

        // R5: wrap past all ones
        wr(A_CTRL, 32'd0);
        wr(A_CNT, 32'hFFFF_FFFE);
        rd(A_CNT, v);
        chk("R5 load readback", v, 32'hFFFF_FFFE);
        wr(A_CTRL, 32'd1);
        idle(3);
        rd(A_CNT, v);
        chk("R5 wrap to 1", v, 32'd1);

        // R6: match control field layout
        wr(A_MCTL, 32'hFFFF_FFFF);
        rd(A_MCTL, v);
        chk("R6 enable bits only", v, 32'h0000_0249);

        // R7/R8/R9: match event with divisor 2
        wr(A_CTRL, 32'd0);
        wr(A_PSC, 32'd2);
        wr(A_M0, 32'd3);
        wr(A_M0 + 4'd1, 32'd2);
        wr(A_MCTL, 32'd1);
        wr(A_FLG, 32'hF);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'd1);
        idle(8);
        rd(A_FLG, v);
        chk("R7 no flag before equality", v, 32'd0);
        idle(1);
        rd(A_FLG, v);
        chk("R7 flag0 set, disabled flag1 clear", v, 32'd1);
        chk("R9 irq with enabled flag", {31'd0, irq}, 32'd1);
        wr(A_FLG, 32'd0);
        rd(A_FLG, v);
        chk("R8 writing zero keeps flag", v, 32'd1);
        wr(A_FLG, 32'd1);
        rd(A_CNT, c1);
        chk("R7 counter still equal", c1, 32'd3);
        rd(A_FLG, v);
        chk("R7 R8 cleared, no re-set while equal", v, 32'd0);
        chk("R9 irq low after clear", {31'd0, irq}, 32'd0);

        // R9/R6: channel 3 enable at bit 9, masking keeps flag
        wr(A_CTRL, 32'd0);
        wr(A_PSC, 32'd0);
        wr(A_M0 + 4'd3, 32'd2);
        wr(A_MCTL, 32'h200);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'd1);
        idle(2);
        rd(A_FLG, v);
        chk("R6 R7 channel 3 flag", v, 32'h8);
        chk("R9 irq from channel 3", {31'd0, irq}, 32'd1);
        wr(A_MCTL, 32'd0);
        #1;
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        rd(A_FLG, v);
        chk("R9 flag kept when masked", v, 32'h8);

        // R10: prescale write restarts the phase
        wr(A_CTRL, 32'd0);
        wr(A_FLG, 32'hF);
        wr(A_PSC, 32'd3);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'd1);
        idle(2);
        wr(A_PSC, 32'd3);
        idle(3);
        rd(A_CNT, v);
        chk("R10 no tick yet after restart", v, 32'd0);
        idle(1);
        rd(A_CNT, v);
        chk("R10 tick after full period", v, 32'd1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule